// File: doc/BRIEF.md
# Dual Prescaler Timer Clock Divider

This block turns one reference clock into five count-enable strobes, one per timer channel. The channels fall into two groups: channels 0 and 1 share one 8-bit prescaler, and channels 2, 3 and 4 share a second one. Each channel then divides its group's prescaled pulse by a power of two that it selects for itself with a 4-bit field. The timer counters sit downstream and advance only in cycles where their strobe is high.

Two configuration words sit on a simple 32-bit register bus and can be written and read back. Any write to either word restarts every prescaler and divider counter from zero. The first strobe after the write therefore already runs at the new rate, and no period mixes old and new settings.

Top module: `tdiv_clkgen`

## Requirements
- R1: After reset, the word at offset 0x00 reads 0x00000101 and the word at offset 0x04 reads 0x00000000.
- R2: A write to offset 0x00 stores data bits [15:0] and a write to offset 0x04 stores data bits [19:0]. A read returns the stored bits, and every bit above them reads as zero.
- R3: A write to any offset other than 0x00 and 0x04 leaves both configuration words unchanged. A read of any such offset returns zero.
- R4: Channels 0 and 1 use the prescaler value P in bits [7:0] of the word at 0x00. Channels 2, 3 and 4 use the value P in bits [15:8].
- R5: With prescaler value P and divider field D, a channel's strobe repeats every (P+1)·2^D reference cycles.
- R6: When its period is longer than one cycle, a strobe is high for exactly one reference cycle per period.
- R7: A write to offset 0x00 or 0x04 restarts all counters. All strobes are low in the cycle after the write edge, and the first strobe of each channel comes (P+1)·2^D clock edges after the write edge.
- R8: Channel c takes its divider field D from bits [4c+3:4c] of the word at offset 0x04, so D may range from 0 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| cfg_addr | input | 8 | Byte offset for reads and writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, combinational |
| tick_o | output | 5 | One count-enable strobe per channel |

## Verification
The assertions assume that a write strobe applies to exactly one offset in the cycle it is sampled. They also assume the bus inputs are settled before each rising edge. The bench drives all bus inputs on the falling edge and holds the write strobe for a single cycle. It draws random prescaler values over the full 8-bit range and divider fields from 0 to 3, so that every period fits in its measuring window. Directed cases cover the extremes: a period of one cycle, different prescalers for the two groups, unmapped offsets, and a divider field of 15.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;
    localparam int BUS_W = 32;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFF_PRE = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_SEL = 8'h04;

    function automatic logic is_mapped(input logic [ADDR_W-1:0] addr);
        return (addr == OFF_PRE) || (addr == OFF_SEL);
    endfunction
endpackage

// File: rtl/tdiv_cfg_regs.sv
module tdiv_cfg_regs
    import tdiv_pkg::*;
#(
    parameter int NCH     = 5,
    parameter int NGRP    = 2,
    parameter int PRE_W   = 8,
    parameter int DIV_W   = 4,
    parameter int PRE_RST = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BUS_W-1:0]        wdata,
    output logic [BUS_W-1:0]        rdata,
    output logic                    restart,
    output logic [NGRP*PRE_W-1:0]   pre_flat,
    output logic [NCH*DIV_W-1:0]    sel_flat
);
    localparam int PBITS = NGRP * PRE_W;
    localparam int SBITS = NCH * DIV_W;

    typedef struct packed {
        logic [PBITS-1:0] pre;
        logic [SBITS-1:0] sel;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        if (wr_en) begin
            if (addr == OFF_PRE) begin
                st_d.pre = wdata[PBITS-1:0];
                restart  = 1'b1;
            end else if (addr == OFF_SEL) begin
                st_d.sel = wdata[SBITS-1:0];
                restart  = 1'b1;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == OFF_PRE) begin
            rdata[PBITS-1:0] = st_q.pre;
        end else if (addr == OFF_SEL) begin
            rdata[SBITS-1:0] = st_q.sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pre <= {NGRP{PRE_W'(PRE_RST)}};
            st_q.sel <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pre_flat = st_q.pre;
    assign sel_flat = st_q.sel;
endmodule

// File: rtl/tdiv_prescaler.sv
module tdiv_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PRE_W-1:0] limit,
    output logic             pulse
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        pulse = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == limit) begin
            st_d.cnt = '0;
            pulse    = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tdiv_chan_div.sv
module tdiv_chan_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             pre_pulse,
    input  logic [DIV_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } div_st_t;

    div_st_t         st_d, st_q;
    logic [CNT_W:0]  span;
    logic [CNT_W-1:0] last;

    always_comb begin
        span = (CNT_W + 1)'(1) << sel;
        last = span[CNT_W-1:0] - CNT_W'(1);
    end

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (pre_pulse) begin
            if (st_q.cnt == last) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;
endmodule

// File: rtl/tdiv_clkgen.sv
module tdiv_clkgen
    import tdiv_pkg::*;
#(
    parameter int NCH     = 5,
    parameter int GRP0_CH = 2,
    parameter int PRE_W   = 8,
    parameter int DIV_W   = 4,
    parameter int PRE_RST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BUS_W-1:0]  cfg_wdata,
    output logic [BUS_W-1:0]  cfg_rdata,
    output logic [NCH-1:0]    tick_o
);
    localparam int NGRP = 2;

    logic                  restart;
    logic [NGRP*PRE_W-1:0] pre_flat;
    logic [NCH*DIV_W-1:0]  sel_flat;
    logic [NGRP-1:0]       pre_pulse;

    tdiv_cfg_regs #(
        .NCH(NCH), .NGRP(NGRP), .PRE_W(PRE_W), .DIV_W(DIV_W), .PRE_RST(PRE_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .restart(restart),
        .pre_flat(pre_flat), .sel_flat(sel_flat)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_pre
        tdiv_prescaler #(.PRE_W(PRE_W)) u_pre (
            .clk(clk), .rst_n(rst_n), .restart(restart),
            .limit(pre_flat[g*PRE_W +: PRE_W]), .pulse(pre_pulse[g])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int GRP = (c < GRP0_CH) ? 0 : 1;
        tdiv_chan_div #(.DIV_W(DIV_W)) u_div (
            .clk(clk), .rst_n(rst_n), .restart(restart),
            .pre_pulse(pre_pulse[GRP]), .sel(sel_flat[c*DIV_W +: DIV_W]),
            .tick(tick_o[c])
        );
    end
endmodule

// File: rtl/tdiv_clkgen_chk.sv
module tdiv_clkgen_chk
    import tdiv_pkg::*;
#(
    parameter int NCH     = 5,
    parameter int GRP0_CH = 2,
    parameter int PRE_W   = 8,
    parameter int DIV_W   = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_wr_en,
    input logic [ADDR_W-1:0]     cfg_addr,
    input logic [BUS_W-1:0]      cfg_wdata,
    input logic [BUS_W-1:0]      cfg_rdata,
    input logic [NCH-1:0]        tick_o,
    input logic [2*PRE_W-1:0]    pre_flat,
    input logic [NCH*DIV_W-1:0]  sel_flat
);
    logic cfg_hit;
    assign cfg_hit = cfg_wr_en && is_mapped(cfg_addr);

    // R7: every strobe is low right after a configuration write
    a_r7_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hit |=> (tick_o == '0));

    // R2: prescaler word captures the written data
    a_r2_pre_update: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == OFF_PRE) |=> (pre_flat == $past(cfg_wdata[2*PRE_W-1:0])));

    // R3: without a mapped write the configuration holds
    a_r3_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_hit |=> ($stable(pre_flat) && $stable(sel_flat)));

    // R3: unmapped reads return zero
    a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !is_mapped(cfg_addr) |-> (cfg_rdata == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        localparam int GRP = (c < GRP0_CH) ? 0 : 1;
        // R6: a strobe lasts one cycle when the period exceeds one cycle
        a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_o[c] && (pre_flat[GRP*PRE_W +: PRE_W] != '0 ||
                           sel_flat[c*DIV_W +: DIV_W] != '0)) |=> !tick_o[c]);
    end
endmodule

bind tdiv_clkgen tdiv_clkgen_chk #(
    .NCH(NCH), .GRP0_CH(GRP0_CH), .PRE_W(PRE_W), .DIV_W(DIV_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tick_o(tick_o),
    .pre_flat(pre_flat), .sel_flat(sel_flat)
);

// File: tb/tdiv_clkgen_test.sv
module tdiv_clkgen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [4:0]  tick_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tdiv_clkgen uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tick_o(tick_o)
    );

    function automatic int exp_period(input logic [31:0] w0, input logic [31:0] w1, input int ch);
        int p;
        int d;
        p = (ch < 2) ? int'(w0[7:0]) : int'(w0[15:8]);
        d = int'(w1[ch*4 +: 4]);
        return (p + 1) << d;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(posedge clk);
        #1;
        cfg_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    // Writes both words, then measures the first two strobes of every channel.
    task automatic run_trial(input logic [31:0] w0, input logic [31:0] w1, input string tag);
        int n[5];
        int first[5];
        int second[5];
        int hits[5];
        int lim;
        lim = 0;
        for (int c = 0; c < 5; c++) begin
            n[c] = exp_period(w0, w1, c);
            first[c] = 0;
            second[c] = 0;
            hits[c] = 0;
            if (2 * n[c] > lim) lim = 2 * n[c];
        end
        bus_write(8'h00, w0);
        bus_write(8'h04, w1);
        check({tag, " R7 quiet after write"}, {27'd0, tick_o}, 32'd0);
        for (int k = 1; k <= lim + 2; k++) begin
            @(posedge clk);
            #1;
            for (int c = 0; c < 5; c++) begin
                if (tick_o[c]) begin
                    if (k <= 2 * n[c]) hits[c]++;
                    if (first[c] == 0) first[c] = k;
                    else if (second[c] == 0) second[c] = k;
                end
            end
        end
        for (int c = 0; c < 5; c++) begin
            check($sformatf("%s R7 ch%0d first strobe", tag, c), first[c], n[c]);
            check($sformatf("%s R5 ch%0d second strobe", tag, c), second[c], 2 * n[c]);
            check($sformatf("%s R6 ch%0d strobe count", tag, c), hits[c], 2);
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] r0;
        logic [31:0] r1;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        check("R1 strobes low in reset", {27'd0, tick_o}, 32'd0);
        rst_n = 1'b1;

        // R1: reset values
        bus_read(8'h00, rd);
        check("R1 word0 reset", rd, 32'h0000_0101);
        bus_read(8'h04, rd);
        check("R1 word1 reset", rd, 32'h0);

        // R2: stored widths and zero upper bits
        bus_write(8'h00, 32'hFFFF_A5C3);
        bus_read(8'h00, rd);
        check("R2 word0 readback", rd, 32'h0000_A5C3);
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_read(8'h04, rd);
        check("R2 word1 readback", rd, 32'h000F_FFFF);

        // R3: unmapped offsets
        bus_write(8'h08, 32'h1234_5678);
        bus_write(8'h01, 32'h0000_0000);
        bus_read(8'h00, rd);
        check("R3 word0 unchanged", rd, 32'h0000_A5C3);
        bus_read(8'h04, rd);
        check("R3 word1 unchanged", rd, 32'h000F_FFFF);
        bus_read(8'h08, rd);
        check("R3 unmapped read zero", rd, 32'h0);

        // Directed corner cases
        run_trial(32'h0000_0000, 32'h0000_0000, "R6 period-one");
        run_trial(32'h0000_0502, 32'h0000_0000, "R4 group split");
        run_trial(32'h0000_0100, 32'h0000_4321, "R8 field position");
        run_trial(32'h0000_0003, 32'h0000_F000, "R8 max divider");

        // Random trials
        for (int t = 0; t < 8; t++) begin
            r0 = {16'd0, 8'($urandom), 8'($urandom)};
            r1 = '0;
            for (int c = 0; c < 5; c++) r1[c*4 +: 4] = 4'($urandom_range(3, 0));
            run_trial(r0, r1, $sformatf("R5 random %0d", t));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule